// File: doc/BRIEF.md
# Shared-leg carrier PWM modulator

This block drives the gates of a single-phase converter built from three half-bridge legs. One leg serves the grid bridge only, one serves the load bridge only, and the third leg is common to both. The grid voltage is the grid pole minus the common pole, and the load voltage is the load pole minus the common pole. The common pole therefore cannot be chosen for one side without moving the other.

The modulator works in two steps. First it computes one offset voltage from the two signed phase references, the DC-bus value E and an apportioning factor. It then adds this offset to each phase reference, and uses the offset itself as the common-leg pole reference. There are four modes:
- the offset can be forced to zero;
- it can be derived from both references together with a single apportioning factor;
- it can be derived from one side only, and then clamped so that the other side stays reachable.

The three pole references are saturated to plus or minus half the bus. They are held for one switching period and compared against a symmetric triangular carrier. That comparison sets each upper switch, and each lower switch is the complement of its upper switch.

Top module: `shared_leg_pwm`

## Requirements
- R1: The three raw pole references are, in this order: grid = grid reference + offset, load = load reference + offset, shared = offset. Gate bit 0 belongs to the grid leg, bit 1 to the load leg and bit 2 to the shared leg.
- R2: When `mode` is 2'b00, the offset is zero.
- R3: When `mode` is 2'b01, let hi = max(grid, load, 0) and lo = min(grid, load, 0), and let m = `mu` / 2^MW. The offset is floor(E·(2m−1)/2 − m·hi + (m−1)·lo), which is exact in units of 2^−(MW+1) before the floor.
- R4: When `mode` is 2'b10 (grid side selected), the offset is the R3 formula with hi = max(grid, 0) and lo = min(grid, 0). The result is then clamped into [−floor(E/2) − load, floor(E/2) − load].
- R5: When `mode` is 2'b11 (load side selected), the offset is the R3 formula with hi = max(load, 0) and lo = min(load, 0). The result is then clamped into [−floor(E/2) − grid, floor(E/2) − grid].
- R6: Each pole reference is saturated to [−floor(E/2), floor(E/2)] before it is compared.
- R7: A step counter runs 0,1,…,N,N−1,…,1,0,… with N = 2^HALF_LOG2, so one period lasts 2N clocks. The carrier is −floor(E/2) + floor(E·count/N).
- R8: An upper gate is 1 exactly when its pole reference is strictly greater than the carrier. Each lower gate is always the inverse of its upper gate.
- R9: The pole references and E are captured only on the clock edge at which the counter is 0 (the trough). Input changes at any other time have no effect until the next trough.
- R10: During reset the counter is 0 and rising, and the held references and E are 0. As a result all upper gates are 0 and all lower gates are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vg_ref | input | DW | Signed grid phase reference |
| vl_ref | input | DW | Signed load phase reference |
| e_bus | input | DW | Signed, non-negative DC-bus value E |
| mode | input | 2 | Offset mode (see R2 to R5) |
| mu | input | MW | Apportioning factor, unsigned fraction of 2^MW |
| gate_hi | output | 3 | Upper switch commands {shared, load, grid} |
| gate_lo | output | 3 | Lower switch commands, complement of gate_hi |

## Verification
The references are swept over a grid that runs from −E to beyond +E for both sides. This grid reaches every ordering of grid, load and zero, which selects which values become the maximum and minimum terms. It also pushes poles into the R6 saturation and local-mode offsets into both R4 and R5 clamp limits. Each pattern is run in all four modes and with factors of 0, one quarter, one half and the largest code, so the two ends of the apportioning range are kept apart. An odd bus value exposes rounding in the half-bus and carrier terms. Inputs change every 11 clocks, which is deliberately out of step with the 16-clock period, so a design that picked up references between troughs would be caught.

// File: rtl/slpwm_pkg.sv
package slpwm_pkg;
  localparam int ACC_W = 40;
  typedef logic signed [ACC_W-1:0] acc_t;

  typedef enum logic [1:0] {
    MODE_FIXED   = 2'b00,
    MODE_GENERAL = 2'b01,
    MODE_LOCAL_G = 2'b10,
    MODE_LOCAL_L = 2'b11
  } share_mode_e;

  function automatic acc_t amax(acc_t a, acc_t b);
    return (a > b) ? a : b;
  endfunction

  function automatic acc_t amin(acc_t a, acc_t b);
    return (a < b) ? a : b;
  endfunction

  function automatic acc_t clamp(acc_t x, acc_t lo, acc_t hi);
    return amax(lo, amin(hi, x));
  endfunction

  // E*(m-1/2) - m*vhi + (m-1)*vlo with m = mq / 2^frac_bits, floored
  function automatic acc_t split_offset(acc_t e, acc_t vhi, acc_t vlo, acc_t mq,
                                        int unsigned frac_bits);
    acc_t one, num;
    one = acc_t'(1) <<< frac_bits;
    num = e * (2 * mq - one) - 2 * mq * vhi + 2 * (mq - one) * vlo;
    return num >>> (frac_bits + 1);
  endfunction

  function automatic acc_t saturate(acc_t x, acc_t half);
    return clamp(x, -half, half);
  endfunction
endpackage

// File: rtl/slpwm_offset.sv
module slpwm_offset
  import slpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int MW = 8,
  parameter int OW = DW + 2
) (
  input  logic signed [DW-1:0] vg,
  input  logic signed [DW-1:0] vl,
  input  logic signed [DW-1:0] e,
  input  logic [1:0]           mode,
  input  logic [MW-1:0]        mu,
  output logic signed [OW-1:0] off
);
  acc_t g, l, ea, half, mq, raw;

  always_comb begin
    g    = acc_t'(vg);
    l    = acc_t'(vl);
    ea   = acc_t'(e);
    mq   = acc_t'({1'b0, mu});
    half = ea >>> 1;
    unique case (share_mode_e'(mode))
      MODE_FIXED:   raw = '0;
      MODE_GENERAL: raw = split_offset(ea, amax(amax(g, l), '0), amin(amin(g, l), '0), mq, MW);
      MODE_LOCAL_G: raw = clamp(split_offset(ea, amax(g, '0), amin(g, '0), mq, MW),
                                -half - l, half - l);
      MODE_LOCAL_L: raw = clamp(split_offset(ea, amax(l, '0), amin(l, '0), mq, MW),
                                -half - g, half - g);
      default:      raw = '0;
    endcase
    off = OW'(raw);
  end
endmodule

// File: rtl/slpwm_carrier.sv
module slpwm_carrier #(
  parameter int DW = 16,
  parameter int HL = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] e_in,
  output logic                 trough,
  output logic [HL:0]          cnt,
  output logic                 up,
  output logic signed [DW:0]   carrier
);
  localparam int N   = 1 << HL;
  localparam int PRW = DW + HL + 3;

  logic signed [DW-1:0]  e_q;
  logic signed [PRW-1:0] e_w, c_w, prod;

  assign trough = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      up  <= 1'b1;
      e_q <= '0;
    end else begin
      if (trough) e_q <= e_in;
      if (up) begin
        cnt <= cnt + 1'b1;
        if (cnt == (HL+1)'(N - 1)) up <= 1'b0;
      end else begin
        cnt <= cnt - 1'b1;
        if (cnt == (HL+1)'(1)) up <= 1'b1;
      end
    end
  end

  always_comb begin
    e_w     = PRW'(e_q);
    c_w     = PRW'($signed({1'b0, cnt}));
    prod    = e_w * c_w;
    carrier = (DW+1)'((prod >>> HL) - (e_w >>> 1));
  end
endmodule

// File: rtl/slpwm_legs.sv
module slpwm_legs
  import slpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int PW = DW + 3,
  parameter int NL = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trough,
  input  logic signed [DW-1:0] e_in,
  input  logic signed [PW-1:0] pole_raw [NL],
  input  logic signed [DW:0]   carrier,
  output logic signed [DW-1:0] pole_q   [NL],
  output logic [NL-1:0]        hi,
  output logic [NL-1:0]        lo
);
  acc_t half;
  assign half = acc_t'(e_in) >>> 1;

  for (genvar i = 0; i < NL; i++) begin : g_leg
    logic signed [DW-1:0] pole_sat;
    assign pole_sat = DW'(saturate(acc_t'(pole_raw[i]), half));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pole_q[i] <= '0;
      else if (trough) pole_q[i] <= pole_sat;
    end

    assign hi[i] = ((DW+1)'(pole_q[i]) > carrier);
    assign lo[i] = ~hi[i];
  end
endmodule

// File: rtl/shared_leg_pwm.sv
module shared_leg_pwm #(
  parameter int DW        = 16,
  parameter int MW        = 8,
  parameter int HALF_LOG2 = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic signed [DW-1:0] vg_ref,
  input  logic signed [DW-1:0] vl_ref,
  input  logic signed [DW-1:0] e_bus,
  input  logic [1:0]           mode,
  input  logic [MW-1:0]        mu,
  output logic [2:0]           gate_hi,
  output logic [2:0]           gate_lo
);
  localparam int OW   = DW + 2;
  localparam int PW   = DW + 3;
  localparam int NLEG = 3;

  logic signed [OW-1:0]  offset;
  logic signed [PW-1:0]  pole_raw [NLEG];
  logic signed [DW-1:0]  pole_q   [NLEG];
  logic                  trough;
  logic [HALF_LOG2:0]    cnt;
  logic                  up;
  logic signed [DW:0]    carrier;

  slpwm_offset #(.DW(DW), .MW(MW), .OW(OW)) u_offset (
    .vg(vg_ref), .vl(vl_ref), .e(e_bus), .mode(mode), .mu(mu), .off(offset)
  );

  assign pole_raw[0] = PW'(vg_ref) + PW'(offset);
  assign pole_raw[1] = PW'(vl_ref) + PW'(offset);
  assign pole_raw[2] = PW'(offset);

  slpwm_carrier #(.DW(DW), .HL(HALF_LOG2)) u_carrier (
    .clk(clk), .rst_n(rst_n), .e_in(e_bus), .trough(trough),
    .cnt(cnt), .up(up), .carrier(carrier)
  );

  slpwm_legs #(.DW(DW), .PW(PW), .NL(NLEG)) u_legs (
    .clk(clk), .rst_n(rst_n), .trough(trough), .e_in(e_bus),
    .pole_raw(pole_raw), .carrier(carrier), .pole_q(pole_q),
    .hi(gate_hi), .lo(gate_lo)
  );
endmodule

// File: rtl/slpwm_checker.sv
module slpwm_checker #(
  parameter int DW = 16,
  parameter int HL = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           mode,
  input logic                 trough,
  input logic [HL:0]          cnt,
  input logic                 up,
  input logic signed [DW:0]   carrier,
  input logic signed [DW-1:0] pole_g,
  input logic signed [DW-1:0] pole_l,
  input logic signed [DW-1:0] pole_a,
  input logic [2:0]           gate_hi
);
  localparam int N = 1 << HL;

  assert_hold_between_troughs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !trough |=> ($stable(pole_g) && $stable(pole_l) && $stable(pole_a)));

  assert_pole_above_floor_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trough |-> ((DW+1)'(pole_g) >= carrier && (DW+1)'(pole_l) >= carrier &&
                (DW+1)'(pole_a) >= carrier));

  assert_peak_all_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == (HL+1)'(N)) |-> (gate_hi == 3'b000));

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (HL+1)'(N));

  assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (up && cnt != (HL+1)'(N)) |=> (cnt == $past(cnt) + 1'b1));

  assert_fixed_shared_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trough && mode == 2'b00) |=> (pole_a == '0));
endmodule

bind shared_leg_pwm slpwm_checker #(.DW(DW), .HL(HALF_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .trough(trough), .cnt(cnt), .up(up),
  .carrier(carrier), .pole_g(pole_q[0]), .pole_l(pole_q[1]), .pole_a(pole_q[2]),
  .gate_hi(gate_hi)
);

// File: tb/shared_leg_pwm_tb.sv
module shared_leg_pwm_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int MW = 8;
  localparam int HL = 3;
  localparam int N  = 1 << HL;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [DW-1:0] vg_ref = '0, vl_ref = '0, e_bus = '0;
  logic [1:0] mode = 2'b00;
  logic [MW-1:0] mu = '0;
  logic [2:0] gate_hi, gate_lo;

  int checks = 0;
  int errors = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_leg_pwm #(.DW(DW), .MW(MW), .HALF_LOG2(HL)) u_dut (
    .clk(clk), .rst_n(rst_n), .vg_ref(vg_ref), .vl_ref(vl_ref), .e_bus(e_bus),
    .mode(mode), .mu(mu), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  function automatic int fdiv(int num, int d);
    int q;
    q = num / d;
    if ((num % d) != 0 && num < 0) q = q - 1;
    return q;
  endfunction

  function automatic int imax(int a, int b); return (a > b) ? a : b; endfunction
  function automatic int imin(int a, int b); return (a < b) ? a : b; endfunction

  // offset = floor((m*(E - hi + lo) - 128E - 256lo)/256) with m in 1/256 units
  function automatic int exp_off(int md, int g, int l, int e, int m);
    int hi, lo, h, x;
    h = e / 2;
    case (md)
      0: return 0;
      1: begin hi = imax(imax(g, l), 0); lo = imin(imin(g, l), 0); end
      2: begin hi = imax(g, 0); lo = imin(g, 0); end
      default: begin hi = imax(l, 0); lo = imin(l, 0); end
    endcase
    x = fdiv(m * (e - hi + lo) - 128 * e - 256 * lo, 256);
    if (md == 2) x = imax(-h - l, imin(h - l, x));
    if (md == 3) x = imax(-h - g, imin(h - g, x));
    return x;
  endfunction

  function automatic int sat(int x, int e);
    return imax(-(e / 2), imin(e / 2, x));
  endfunction

  // reference model of the period, from R7 and R9
  int m_cnt = 0, m_e = 0, m_pg = 0, m_pl = 0, m_pa = 0;
  bit m_up = 1'b1;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_up = 1'b1; m_e = 0; m_pg = 0; m_pl = 0; m_pa = 0;
    end else begin
      if (m_cnt == 0) begin
        int o;
        o = exp_off(int'(mode), int'(vg_ref), int'(vl_ref), int'(e_bus), int'(mu));
        m_e  = int'(e_bus);
        m_pg = sat(int'(vg_ref) + o, m_e);
        m_pl = sat(int'(vl_ref) + o, m_e);
        m_pa = sat(o, m_e);
      end
      if (m_up) begin m_cnt++; if (m_cnt == N) m_up = 1'b0; end
      else begin m_cnt--; if (m_cnt == 0) m_up = 1'b1; end
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      int car;
      logic [2:0] exp_hi;
      string tag;
      car = -(m_e / 2) + (m_e * m_cnt) / N;
      exp_hi = {m_pa > car, m_pl > car, m_pg > car};
      case (mode)
        2'b00: tag = "R2";
        2'b01: tag = "R3";
        2'b10: tag = "R4";
        default: tag = "R5";
      endcase
      checks++;
      if (gate_hi !== exp_hi || gate_lo !== ~exp_hi) begin
        errors++;
        $display("FAIL %s R1 R6 R7 R8 R9: gate_hi=%b gate_lo=%b expected hi=%b lo=%b (cnt=%0d)",
                 tag, gate_hi, gate_lo, exp_hi, ~exp_hi, m_cnt);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int evals [3];
    int mus [4];
    evals = '{1000, 999, 64};
    mus   = '{0, 64, 128, 255};
    repeat (3) @(negedge clk);
    // R10: reset state
    checks++;
    if (gate_hi !== 3'b000 || gate_lo !== 3'b111) begin
      errors++;
      $display("FAIL R10: gate_hi=%b gate_lo=%b expected 000 111", gate_hi, gate_lo);
    end
    rst_n = 1'b1;
    chk_en = 1'b1;
    foreach (evals[ei]) begin
      for (int md = 0; md < 4; md++) begin
        foreach (mus[mi]) begin
          for (int gi = 0; gi < 8; gi++) begin
            for (int li = 0; li < 8; li++) begin
              e_bus  = DW'(evals[ei]);
              mode   = 2'(md);
              mu     = MW'(mus[mi]);
              vg_ref = DW'(((gi - 3) * evals[ei]) / 3);
              vl_ref = DW'(((li - 3) * evals[ei]) / 3);
              repeat (11) @(negedge clk);
            end
          end
        end
      end
    end
    chk_en = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule